// File: doc/BRIEF.md
# Quadrant Phase Synchronizer Controller

This block keeps the hand-off from a data-clock domain into a faster converter clock aligned. Every incoming word is spread over four phase slots of the converter clock, called quadrants. The controller decides which quadrant is active. It picks that quadrant from a vector of four phase-valid flags, which a phase detector outside this block produces. It runs in automatic, manual or external-override mode and reports the active quadrant and an alarm flag. The report comes through a status readback word and, when the register interface is strapped off, through a spare output pin.

An update request always causes a resynchronization, in every mode. In automatic mode the controller also resynchronizes by itself when the active quadrant goes bad, and on the first phase measurement after reset. In manual mode the quadrant moves only on request, so system software can place updates in the gaps between data bursts. External mode works on top of manual mode. It replaces the computed quadrant with a value held in configuration, so that several converters can be set to the same latency.

Top module: `qsync_ctrl`

## Requirements
- R1: After reset the active quadrant is 0, the alarm is clear and the spare alarm pin is low.
- R2: The readback word always carries the active quadrant in bits [1:0] and the alarm in bit 7, with all other bits zero.
- R3: A rising edge on the selected request input is passed through a two-flop synchronizer and then edge-detected. The new quadrant appears on the fourth rising clock edge after the request rises, and never earlier. This happens in every mode, including automatic.
- R4: Outside external mode, the chosen quadrant is the lowest index whose phase-valid flag is set. If no flag is set, the quadrant keeps its value.
- R5: In manual mode the quadrant changes only as the result of an update request. An alarm does not change the quadrant.
- R6: The alarm is set one edge after a measurement strobe finds the active quadrant's phase-valid flag clear. The alarm holds until the next update, which clears it in the same edge that applies the new quadrant.
- R7: In automatic mode a raised alarm starts a resynchronization by itself. The new quadrant appears on the third edge after the measurement strobe that raised the alarm.
- R8: In automatic mode, the first measurement strobe after reset starts an update. The new quadrant appears on the second edge after that strobe.
- R9: External mode is active only when both the manual bit and the external bit are set and the register interface is enabled. An update then loads the configured 2-bit quadrant. The external bit alone has no effect.
- R10: While the register-interface-disable strap is high, the following hold. Manual mode is forced. Requests are taken only from the spare request pin, and the register request is ignored. External mode is ignored. The alarm is driven onto the spare alarm pin. While the strap is low, the alarm pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_manual | input | 1 | Manual-mode configuration bit |
| cfg_ext | input | 1 | External-override configuration bit |
| cfg_ext_quad | input | 2 | Quadrant loaded in external mode |
| regif_dis | input | 1 | Strap: register interface disabled |
| upd_req | input | 1 | Register update request (asynchronous level) |
| upd_pin | input | 1 | Spare-pin update request (asynchronous level) |
| meas_vld | input | 1 | Strobe: phase_ok holds a fresh measurement |
| phase_ok | input | 4 | Phase-valid flag for each quadrant |
| quad_o | output | 2 | Active quadrant |
| alarm_o | output | 1 | Misalignment alarm |
| alarm_pin_o | output | 1 | Alarm on the spare pin (strap high only) |
| rb_status | output | 8 | Status readback word |

## Verification
The assertions assume that the configuration bits and the strap change only while no update is in flight. They also assume that the request-source selection changes only while both request inputs are low, so switching sources cannot create a false edge. The manual-mode properties further assume that any update two cycles back came from a request edge, and not from an automatic launch started just before manual mode was entered. The bench follows all of this. It changes configuration and strap only between scenarios, after waiting out any pending update. It holds every request low during those changes. Measurement strobes last one cycle and never coincide with an update being applied.

// File: rtl/qsync_pkg.sv
package qsync_pkg;
  localparam int unsigned QSYNC_NQ_DEF    = 4;
  localparam int unsigned QSYNC_STAGE_DEF = 2;
  localparam int unsigned QSYNC_RB_DEF    = 8;

  typedef enum logic [1:0] {
    QMODE_AUTO   = 2'd0,
    QMODE_MANUAL = 2'd1,
    QMODE_EXT    = 2'd2
  } qmode_e;
endpackage

// File: rtl/qsync_req_sync.sv
module qsync_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = req_async;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], req_async};
    end
  endgenerate

  always_comb last_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/qsync_quad_pick.sv
module qsync_quad_pick #(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic [NQ-1:0] phase_ok,
  output logic [QW-1:0] pick_idx,
  output logic          pick_any
);
  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (phase_ok[i]) begin
        pick_idx = QW'(i);
        pick_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qsync_mode_ctrl.sv
module qsync_mode_ctrl
  import qsync_pkg::*;
#(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_manual,
  input  logic          cfg_ext,
  input  logic [QW-1:0] cfg_ext_quad,
  input  logic          regif_dis,
  input  logic          upd_edge,
  input  logic          meas_vld,
  input  logic [NQ-1:0] phase_ok,
  input  logic [QW-1:0] pick_idx,
  input  logic          pick_any,
  output logic [QW-1:0] quad_o,
  output logic          alarm_o
);
  qmode_e        mode;
  logic [QW-1:0] quad_q, quad_d;
  logic          alarm_q, alarm_d;
  logic          pend_q, pend_d;
  logic          seen_q, seen_d;
  logic          auto_go, go;
  logic          act_bad;

  always_comb begin
    if (regif_dis || !cfg_manual) mode = regif_dis ? QMODE_MANUAL : QMODE_AUTO;
    else if (cfg_ext)             mode = QMODE_EXT;
    else                          mode = QMODE_MANUAL;
  end

  always_comb begin
    act_bad = meas_vld && !phase_ok[quad_q];
    auto_go = (mode == QMODE_AUTO) && !pend_q &&
              (alarm_q || (meas_vld && !seen_q));
    go      = upd_edge || auto_go;
  end

  always_comb begin
    quad_d  = quad_q;
    alarm_d = alarm_q;
    pend_d  = go;
    seen_d  = seen_q || meas_vld;
    if (pend_q) begin
      alarm_d = 1'b0;
      if (mode == QMODE_EXT) quad_d = cfg_ext_quad;
      else if (pick_any)     quad_d = pick_idx;
    end else if (act_bad) begin
      alarm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q  <= '0;
      alarm_q <= 1'b0;
      pend_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      seen_q  <= seen_d;
      alarm_q <= alarm_d;
      if (pend_q) quad_q <= quad_d;
    end
  end

  assign quad_o  = quad_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/qsync_ctrl.sv
module qsync_ctrl
  import qsync_pkg::*;
#(
  parameter int unsigned NQ     = QSYNC_NQ_DEF,
  parameter int unsigned STAGES = QSYNC_STAGE_DEF,
  parameter int unsigned RB_W   = QSYNC_RB_DEF,
  localparam int unsigned QW    = $clog2(NQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_manual,
  input  logic            cfg_ext,
  input  logic [QW-1:0]   cfg_ext_quad,
  input  logic            regif_dis,
  input  logic            upd_req,
  input  logic            upd_pin,
  input  logic            meas_vld,
  input  logic [NQ-1:0]   phase_ok,
  output logic [QW-1:0]   quad_o,
  output logic            alarm_o,
  output logic            alarm_pin_o,
  output logic [RB_W-1:0] rb_status
);
  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          req_src;
  logic          upd_edge_w;
  logic [QW-1:0] pick_idx_w;
  logic          pick_any_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign req_src = regif_dis ? upd_pin : upd_req;

  qsync_req_sync #(.STAGES(STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_async (req_src),
    .edge_o    (upd_edge_w)
  );

  qsync_quad_pick #(.NQ(NQ)) u_pick (
    .phase_ok (phase_ok),
    .pick_idx (pick_idx_w),
    .pick_any (pick_any_w)
  );

  qsync_mode_ctrl #(.NQ(NQ)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cfg_manual   (cfg_manual),
    .cfg_ext      (cfg_ext),
    .cfg_ext_quad (cfg_ext_quad),
    .regif_dis    (regif_dis),
    .upd_edge     (upd_edge_w),
    .meas_vld     (meas_vld),
    .phase_ok     (phase_ok),
    .pick_idx     (pick_idx_w),
    .pick_any     (pick_any_w),
    .quad_o       (quad_o),
    .alarm_o      (alarm_o)
  );

  assign alarm_pin_o = regif_dis & alarm_o;

  always_comb begin
    rb_status           = '0;
    rb_status[QW-1:0]   = quad_o;
    rb_status[RB_W-1]   = alarm_o;
  end
endmodule

// File: rtl/qsync_ctrl_chk.sv
module qsync_ctrl_chk #(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_manual,
  input logic          cfg_ext,
  input logic [QW-1:0] cfg_ext_quad,
  input logic          regif_dis,
  input logic          meas_vld,
  input logic [NQ-1:0] phase_ok,
  input logic          upd_edge,
  input logic [QW-1:0] pick_idx,
  input logic          pick_any,
  input logic [QW-1:0] quad,
  input logic          alarm,
  input logic          alarm_pin
);
  logic man_eff, ext_eff;
  assign man_eff = cfg_manual | regif_dis;
  assign ext_eff = cfg_manual & cfg_ext & ~regif_dis;

  assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_edge |=> !upd_edge);

  assert_pick_applied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_edge) && !ext_eff && pick_any |=> quad == $past(pick_idx));

  assert_manual_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    man_eff && $past(man_eff, 2) && !$stable(quad) |-> $past(upd_edge, 2));

  assert_alarm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_edge) |=> !alarm);

  assert_alarm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    man_eff && meas_vld && !phase_ok[quad] && !$past(upd_edge) |=> alarm);

  assert_ext_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_edge) && ext_eff |=> quad == $past(cfg_ext_quad));

  assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !regif_dis |-> !alarm_pin);

  assert_pin_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    regif_dis |-> alarm_pin == alarm);
endmodule

bind qsync_ctrl qsync_ctrl_chk #(.NQ(NQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .cfg_manual   (cfg_manual),
  .cfg_ext      (cfg_ext),
  .cfg_ext_quad (cfg_ext_quad),
  .regif_dis    (regif_dis),
  .meas_vld     (meas_vld),
  .phase_ok     (phase_ok),
  .upd_edge     (upd_edge_w),
  .pick_idx     (pick_idx_w),
  .pick_any     (pick_any_w),
  .quad         (quad_o),
  .alarm        (alarm_o),
  .alarm_pin    (alarm_pin_o)
);

// File: tb/tb_qsync_ctrl.sv
module tb_qsync_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_manual, cfg_ext, regif_dis, upd_req, upd_pin, meas_vld;
  logic [1:0] cfg_ext_quad;
  logic [3:0] phase_ok;
  logic [1:0] quad_o;
  logic       alarm_o, alarm_pin_o;
  logic [7:0] rb_status;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qsync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_manual(cfg_manual), .cfg_ext(cfg_ext),
    .cfg_ext_quad(cfg_ext_quad), .regif_dis(regif_dis), .upd_req(upd_req),
    .upd_pin(upd_pin), .meas_vld(meas_vld), .phase_ok(phase_ok),
    .quad_o(quad_o), .alarm_o(alarm_o), .alarm_pin_o(alarm_pin_o),
    .rb_status(rb_status)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle measurement strobe; returns at the negedge after one posedge
  task automatic strobe(input logic [3:0] ok);
    phase_ok = ok;
    meas_vld = 1'b1;
    @(negedge clk);
    meas_vld = 1'b0;
  endtask

  // request with quadrant checked just before and at the fourth edge
  task automatic send_req(input bit via_pin, input int q_old, input int q_new,
                          input string req);
    if (via_pin) upd_pin = 1'b1; else upd_req = 1'b1;
    idle(3);
    check({req, " quad before 4th edge"}, quad_o, q_old);
    idle(1);
    check({req, " quad at 4th edge"}, quad_o, q_new);
    upd_pin = 1'b0;
    upd_req = 1'b0;
    idle(4);
  endtask

  task automatic t_reset;
    check("R1 quad", quad_o, 0);
    check("R1 alarm", alarm_o, 0);
    check("R1 alarm pin", alarm_pin_o, 0);
    check("R2 readback after reset", rb_status, 0);
  endtask

  task automatic t_first_meas;
    strobe(4'b1100);
    check("R6 alarm one edge after bad strobe", alarm_o, 1);
    check("R8 quad not yet moved", quad_o, 0);
    idle(1);
    check("R8 first measurement update", quad_o, 2);
    check("R6 alarm cleared by update", alarm_o, 0);
    check("R2 readback quad", rb_status, 8'h02);
    idle(3);
  endtask

  task automatic t_auto_alarm;
    strobe(4'b1011);
    check("R2 readback with alarm", rb_status, 8'h82);
    idle(1);
    check("R7 quad held one edge more", quad_o, 2);
    idle(1);
    check("R7 auto resync quad", quad_o, 0);
    check("R7 alarm cleared", alarm_o, 0);
    idle(3);
  endtask

  task automatic t_auto_req;
    phase_ok = 4'b1010;
    send_req(1'b0, 0, 1, "R3 auto-mode request, R4 tie lowest");
  endtask

  task automatic t_manual;
    cfg_manual = 1'b1;
    idle(2);
    strobe(4'b1000);
    check("R6 manual alarm set", alarm_o, 1);
    idle(10);
    check("R5 alarm holds in manual", alarm_o, 1);
    check("R5 quad holds in manual", quad_o, 1);
    send_req(1'b0, 1, 3, "R5 manual request");
    check("R6 alarm cleared by request", alarm_o, 0);
  endtask

  task automatic t_none;
    phase_ok = 4'b0000;
    send_req(1'b0, 3, 3, "R4 no valid flag keeps quad");
  endtask

  task automatic t_ext;
    cfg_ext      = 1'b1;
    cfg_ext_quad = 2'd1;
    phase_ok     = 4'b0001;
    idle(2);
    send_req(1'b0, 3, 1, "R9 external quad loaded");
    cfg_manual   = 1'b0;
    cfg_ext_quad = 2'd2;
    idle(2);
    send_req(1'b0, 1, 0, "R9 ext bit alone ignored");
    cfg_ext = 1'b0;
    idle(2);
  endtask

  task automatic t_regif;
    regif_dis = 1'b1;
    idle(2);
    strobe(4'b0100);
    check("R10 alarm set", alarm_o, 1);
    check("R10 alarm on pin", alarm_pin_o, 1);
    idle(8);
    check("R10 forced manual: no auto resync", quad_o, 0);
    send_req(1'b0, 0, 0, "R10 register request ignored");
    send_req(1'b1, 0, 2, "R10 pin request");
    check("R10 pin low after update", alarm_pin_o, 0);
    cfg_manual   = 1'b1;
    cfg_ext      = 1'b1;
    cfg_ext_quad = 2'd3;
    phase_ok     = 4'b0010;
    idle(2);
    send_req(1'b1, 2, 1, "R10 ext ignored while strapped");
    regif_dis = 1'b0;
    cfg_ext   = 1'b0;
    idle(2);
    strobe(4'b0000);
    check("R10 alarm raised with strap low", alarm_o, 1);
    check("R10 pin quiet with strap low", alarm_pin_o, 0);
    idle(2);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_manual = 1'b0; cfg_ext = 1'b0; cfg_ext_quad = 2'd0;
    regif_dis = 1'b0; upd_req = 1'b0; upd_pin = 1'b0;
    meas_vld = 1'b0; phase_ok = 4'b0000;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_first_meas();
    t_auto_alarm();
    t_auto_req();
    t_manual();
    t_none();
    t_ext();
    t_regif();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule